// File: doc/BRIEF.md
# CORDIC Sine and Cosine Generator

This block turns a stream of phase words into a stream of sine and cosine samples. A phase is an unsigned 19-bit fraction of a full turn. The block accepts phases on a valid/ready input and returns signed (sin, cos) pairs on a valid/ready output, in the order the phases arrived. Inside is a register chain of shift-and-add rotation stages, one stage per output bit, so a new phase can enter on every clock.

On entry, a phase in the left half of the circle is moved by half a turn, and the starting vector is negated to make up for it. The phase the stages see then lies between minus and plus a quarter turn. Each stage turns the working vector by a fixed arctangent step and moves the leftover phase the other way. The direction of each step comes from the sign of the leftover phase.

Gain compensation is a build-time option. With it off, the outputs carry the full rotation gain of about 1.6468. The default start magnitude of 724 then gives a peak of about 1192. With it on, the start vector is pre-scaled so that the peak is close to the start magnitude. A stall on the output freezes the whole chain, and the input stops taking phases until the stall ends. The rotation stage is its own module, with its step index and angle constant set at build time, so it can be tested alone.

Top module: `cordic_sincos`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `dout_valid` is 0 and `din_ready` is 1.
- R2: For any phase p (unsigned, 2^19 = one full turn, so the angle is 2*pi*p/2^19), with gain compensation off, `dout_sin` and `dout_cos` are within 2 LSB of round(1192.2*sin) and round(1192.2*cos). This holds in all four quadrants.
- R3: With gain compensation off, the outputs at these points are within 2 LSB of the values given: p=0 gives (0, 1192); p=2^17 gives (1192, 0); p=2^18 gives (0, -1192); p=2^19-1 gives (0, 1192); p=43691 (pi/6) gives (596, 1032).
- R4: There is exactly one output pair for each accepted phase, and the pairs leave in the order the phases were accepted.
- R5: While `dout_ready` is held at 1, the result of a phase accepted at clock edge E is first seen on `dout_valid` after edge E+12, which is one edge per output bit.
- R6: While `dout_ready` is 1, `din_ready` is 1, so one phase is taken on every clock.
- R7: If `dout_valid` is 1 and `dout_ready` is 0 at an edge, then after that edge `dout_valid` is still 1 and both samples are unchanged. While this stall lasts, `din_ready` is 0.
- R8: With gain compensation on (`NORM_GAIN`=1), the outputs are within 3 LSB of round(724*sin) and round(724*cos).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din_valid | input | 1 | A phase word is offered |
| din_phase | input | 19 | Unsigned phase, 2^19 is one full turn |
| din_ready | output | 1 | The block takes the offered phase on this edge |
| dout_valid | output | 1 | A sample pair is offered |
| dout_ready | input | 1 | The consumer takes the offered pair |
| dout_sin | output | 12 | Signed sine sample |
| dout_cos | output | 12 | Signed cosine sample |

## Verification
A wrong rotation direction, a wrong angle constant or a bad fold at any stage shows up as a sample error, much larger than 2 LSB, on the result of the phase that passed through it. That result comes out 12 cycles later. Folding mistakes show up only in the left half of the circle, so the stimulus covers every quadrant and the edges at a quarter, a half and just below a full turn. A slip in the valid chain or in the stall logic shows up at the ports as a lost, doubled or reordered pair, or as a sample that changes during a stall. The scoreboard reports it the moment the next pair arrives.

// File: rtl/cordic_rot_stage.sv
module cordic_rot_stage #(
  parameter int IDX = 0,
  parameter int W   = 15,
  parameter int ZW  = 20,
  parameter logic signed [ZW-1:0] ANGLE = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 vin,
  input  logic signed [W-1:0]  xin,
  input  logic signed [W-1:0]  yin,
  input  logic signed [ZW-1:0] zin,
  output logic                 vout,
  output logic signed [W-1:0]  xout,
  output logic signed [W-1:0]  yout,
  output logic signed [ZW-1:0] zout
);
  wire signed [W-1:0] xs = xin >>> IDX;
  wire signed [W-1:0] ys = yin >>> IDX;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  vout <= 1'b0;
    else if (en) vout <= vin;

  always_ff @(posedge clk)
    if (en) begin
      if (zin[ZW-1]) begin
        xout <= xin + ys;
        yout <= yin - xs;
        zout <= zin + ANGLE;
      end else begin
        xout <= xin - ys;
        yout <= yin + xs;
        zout <= zin - ANGLE;
      end
    end
endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos #(
  parameter int OW        = 12,
  parameter int PW        = 19,
  parameter int GUARD     = 3,
  parameter int AMP       = 724,
  parameter bit NORM_GAIN = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 din_valid,
  input  logic [PW-1:0]        din_phase,
  output logic                 din_ready,
  output logic                 dout_valid,
  input  logic                 dout_ready,
  output logic signed [OW-1:0] dout_sin,
  output logic signed [OW-1:0] dout_cos
);
  localparam int N  = OW;
  localparam int W  = OW + GUARD;
  localparam int ZW = PW + 1;
  localparam int X0MAG = NORM_GAIN ? (AMP * 39797 + 32768) / 65536 : AMP;
  localparam logic signed [W-1:0] X0  = W'(X0MAG * (1 << GUARD));
  localparam logic signed [W-1:0] RND = W'(1 << (GUARD - 1));

  // arctan(2^-i) as a fraction of a turn, scaled by 2^32
  function automatic longint turn32(input int i);
    case (i)
      0:  return 64'd536870912;
      1:  return 64'd316933406;
      2:  return 64'd167458907;
      3:  return 64'd85004756;
      4:  return 64'd42667331;
      5:  return 64'd21354465;
      6:  return 64'd10679838;
      7:  return 64'd5340245;
      8:  return 64'd2670163;
      9:  return 64'd1335087;
      10: return 64'd667544;
      11: return 64'd333772;
      12: return 64'd166886;
      13: return 64'd83443;
      14: return 64'd41722;
      15: return 64'd20861;
      default: return 64'd0;
    endcase
  endfunction

  function automatic longint step_angle(input int i);
    return (turn32(i) + (64'sd1 <<< (31 - PW))) >>> (32 - PW);
  endfunction

  localparam logic signed [ZW-1:0] QTR  = ZW'(64'sd1 <<< (PW - 2));
  localparam logic signed [ZW-1:0] ZLIM = ZW'(step_angle(N - 1) + N);
  localparam logic signed [OW-1:0] OLIM =
    OW'((NORM_GAIN ? AMP : (AMP * 17 + 9) / 10) + 4);

  logic               vs [0:N];
  logic signed [W-1:0]  xs [0:N];
  logic signed [W-1:0]  ys [0:N];
  logic signed [ZW-1:0] zs [0:N];

  wire en = !vs[N] || dout_ready;
  assign din_ready  = en;
  assign dout_valid = vs[N];

  // fold the left half of the circle onto the right half
  wire far    = din_phase[PW-1] ^ din_phase[PW-2];
  wire top_hi = din_phase[PW-1] ^ far;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  vs[0] <= 1'b0;
    else if (en) vs[0] <= din_valid;

  always_ff @(posedge clk)
    if (en) begin
      xs[0] <= far ? -X0 : X0;
      ys[0] <= '0;
      zs[0] <= {top_hi, top_hi, din_phase[PW-2:0]};
    end

  for (genvar k = 0; k < N; k++) begin : g_stage
    localparam logic signed [ZW-1:0] ANG = ZW'(step_angle(k));
    cordic_rot_stage #(.IDX(k), .W(W), .ZW(ZW), .ANGLE(ANG)) u_st (
      .clk(clk), .rst_n(rst_n), .en(en),
      .vin(vs[k]), .xin(xs[k]), .yin(ys[k]), .zin(zs[k]),
      .vout(vs[k+1]), .xout(xs[k+1]), .yout(ys[k+1]), .zout(zs[k+1])
    );
  end

  assign dout_sin = OW'((ys[N] + RND) >>> GUARD);
  assign dout_cos = OW'((xs[N] + RND) >>> GUARD);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !dout_valid && din_ready); // R1
  AST_FOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vs[0] |-> (zs[0] <= QTR) && (zs[0] >= -QTR)); // R2
  AST_RESIDUAL: assert property (@(posedge clk) disable iff (!rst_n)
    vs[N] |-> (zs[N] <= ZLIM) && (zs[N] >= -ZLIM)); // R2
  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> (dout_sin <= OLIM) && (dout_sin >= -OLIM) &&
                   (dout_cos <= OLIM) && (dout_cos >= -OLIM)); // R2
  AST_ACCEPT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    dout_ready |-> din_ready); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid && !dout_ready |=> dout_valid && $stable(dout_sin) && $stable(dout_cos)); // R7
endmodule

// File: tb/sim_cordic_sincos.sv
`timescale 1ns/1ps
module sim_cordic_sincos;
  localparam real KG = 1.6467602;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic din_valid = 1'b0, dout_ready = 1'b1;
  logic [18:0] din_phase = '0;
  logic din_ready, dout_valid;
  logic signed [11:0] dout_sin, dout_cos;

  logic n_valid = 1'b0;
  logic [18:0] n_phase = '0;
  logic n_ready, n_dvalid;
  logic signed [11:0] n_sin, n_cos;

  cordic_sincos u0 (
    .clk(clk), .rst_n(rst_n), .din_valid(din_valid), .din_phase(din_phase),
    .din_ready(din_ready), .dout_valid(dout_valid), .dout_ready(dout_ready),
    .dout_sin(dout_sin), .dout_cos(dout_cos));

  cordic_sincos #(.NORM_GAIN(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .din_valid(n_valid), .din_phase(n_phase),
    .din_ready(n_ready), .dout_valid(n_dvalid), .dout_ready(1'b1),
    .dout_sin(n_sin), .dout_cos(n_cos));

  int checks = 0, fails = 0;
  bit stall_en = 1'b0, finished = 1'b0;
  int rcnt = 0;
  int q_sin[$], q_cos[$];
  string q_tag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int ideal(input real amp, input logic [18:0] ph, input bit want_sin);
    real a;
    a = TWO_PI * real'(ph) / 524288.0;
    return want_sin ? int'(amp * $sin(a)) : int'(amp * $cos(a));
  endfunction

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", q_sin.size(), 0);
    finish_run();
  end

  initial forever begin
    @(negedge clk);
    rcnt++;
    dout_ready = !stall_en || ((rcnt % 5) >= 2);
  end

  bit held = 1'b0;
  int hs = 0, hc = 0;
  initial forever begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (held)
        check(dout_valid && dout_sin == hs && dout_cos == hc, "R7",
              "output held over stall", dout_sin, hs);
      held = 1'b0;
      if (dout_valid && !dout_ready) begin
        check(!din_ready, "R7", "din_ready during stall", din_ready, 0);
        held = 1'b1; hs = dout_sin; hc = dout_cos;
      end
      if (dout_valid && dout_ready) begin
        if (q_sin.size() == 0) check(1'b0, "R4", "unexpected output", dout_sin, 0);
        else begin
          int es, ec;
          string tg;
          es = q_sin.pop_front(); ec = q_cos.pop_front(); tg = q_tag.pop_front();
          check(absd(dout_sin, es) <= 2, tg, "sin", dout_sin, es);
          check(absd(dout_cos, ec) <= 2, tg, "cos", dout_cos, ec);
        end
      end
    end
  end

  // called at a falling edge; returns at a falling edge after acceptance
  task automatic send(input logic [18:0] ph, input string tag, output int waits);
    waits = 0;
    din_valid = 1'b1; din_phase = ph;
    #2;
    while (!din_ready) begin
      waits++;
      @(negedge clk); #2;
    end
    q_sin.push_back(ideal(724.0 * KG, ph, 1'b1));
    q_cos.push_back(ideal(724.0 * KG, ph, 1'b0));
    q_tag.push_back(tag);
    @(negedge clk);
    din_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (q_sin.size() != 0 && n < 400) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic norm_probe(input logic [18:0] ph);
    int lat = 0;
    n_valid = 1'b1; n_phase = ph;
    @(negedge clk);
    n_valid = 1'b0;
    while (!n_dvalid && lat < 40) begin @(negedge clk); lat++; end
    check(absd(n_sin, ideal(724.0, ph, 1'b1)) <= 3, "R8", "normalised sin",
          n_sin, ideal(724.0, ph, 1'b1));
    check(absd(n_cos, ideal(724.0, ph, 1'b0)) <= 3, "R8", "normalised cos",
          n_cos, ideal(724.0, ph, 1'b0));
  endtask

  initial begin
    int w, wsum, lat;
    repeat (3) @(negedge clk);
    #2;
    check(!dout_valid && din_ready, "R1", "idle during reset", dout_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(!dout_valid, "R1", "dout_valid after reset", dout_valid, 0);
    check(din_ready, "R1", "din_ready after reset", din_ready, 1);
    @(negedge clk);

    send(19'd0, "R3", w);
    send(19'd131072, "R3", w);
    send(19'd262144, "R3", w);
    send(19'd524287, "R3", w);
    send(19'd43691, "R3", w);
    send(19'd65536, "R2", w);
    send(19'd327680, "R2", w);
    send(19'd393216, "R2", w);
    send(19'd458752, "R2", w);
    send(19'd131071, "R2", w);
    send(19'd262145, "R2", w);
    drain();

    send(19'd200000, "R5", w);
    lat = 0;
    while (!dout_valid && lat < 40) begin @(negedge clk); lat++; end
    check(lat == 12, "R5", "latency in cycles", lat, 12);
    drain();

    wsum = 0;
    for (int i = 0; i < 40; i++) begin
      send(19'(i * 13107 + 7), "R6", w);
      wsum += w;
    end
    check(wsum == 0, "R6", "input wait cycles while unstalled", wsum, 0);
    drain();

    stall_en = 1'b1;
    for (int i = 0; i < 60; i++) send(19'(i * 8737 + 3), "R2", w);
    stall_en = 1'b0;
    drain();
    check(q_sin.size() == 0, "R4", "pairs left unmatched", q_sin.size(), 0);

    norm_probe(19'd0);
    norm_probe(19'd131072);
    norm_probe(19'd327680);
    norm_probe(19'd458752);

    finish_run();
  end
endmodule